// File: doc/BRIEF.md
# Host Register Bank with Pointer Side Effects

This block is the register file that a host controller reaches through a narrow parallel port. It holds thirty-two 16-bit locations selected by a 5-bit address. Every location can be read. A subset can be written and drives configuration outputs for the rest of the signal chain. Locations that are read-only show live measurements, a status word or a fixed version number.

Some accesses also move internal pointers. Each write to the curve-entry location stores one word into an internal 1024-word transfer-curve table and advances the table's write address. Each read of the history location returns the sample at the current history pointer and advances that pointer. The history storage itself sits outside the block. Reading the status location returns both pointers to zero. The host reads the status location first, then streams a whole curve in or a whole history out. The status word forces its bits 6, 7, 14 and 15 so that each of its two bytes is a printable character.

Top module: `host_regfile`

## Requirements
- R1: The writable locations 0, 1, 8, 10, 11, 12, 14, 15 and 20 keep all 16 written bits. They read back unchanged, and each drives its configuration output.
- R2: The control location 6 and the gain locations 13, 16, 17 and 18 keep only data bits 7:0. Bits 15:8 of these locations read as zero.
- R3: A write to a read-only location (2, 3, 7, 19, 21, 22, 23) or to an unused location (4, 5, 9, 24 to 31) changes nothing. Unused locations read as zero.
- R4: The status word (location 7) is laid out as follows:
  - bit 0: DAC overflow
  - bit 1: DAC underflow
  - bit 2: accumulator overflow
  - bit 3: accumulator underflow
  - bit 4: TTL input
  - bits 6 and 14: always 1
  - bits 5, 7, 13:8 and 15: always 0
- R5: A read of location 7 sets the curve write address and the history pointer to 0 on the same clock edge.
- R6: A write to location 20 stores the data at the current curve write address and adds one to that address. The stored word appears on `curve_rdata` one cycle after `curve_raddr` selects it.
- R7: A read of location 19 returns `hist_data` as it stands at the current `hist_ptr`, then adds one to `hist_ptr`. Control bit 7 (`ctl_bits[7]`, 0 = ADC history, 1 = DAC history) selects the external source.
- R8: The curve write address and the history pointer both wrap from 1023 to 0.
- R9: The following read-only locations return live or fixed values:
  - location 2: bits 31:16 of `freq_count`
  - location 3: bits 15:0 of `freq_count`
  - location 21: the version constant (default 16'h0107)
  - location 22: `adc_now`
  - location 23: `dac_now`
- R10: `host_rdata` takes the selected word on a clock edge where `host_rd` is high and holds its value otherwise. It resets to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 5 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| dac_ovf | input | 1 | DAC clipped at upper limit |
| dac_unf | input | 1 | DAC clipped at lower limit |
| acc_ovf | input | 1 | Integrator clipped at upper limit |
| acc_unf | input | 1 | Integrator clipped at lower limit |
| ttl_in | input | 1 | TTL input level |
| freq_count | input | 32 | Measured oscillator frequency |
| adc_now | input | 16 | Current ADC sample |
| dac_now | input | 16 | Current DAC output |
| hist_ptr | output | 10 | History read pointer to external store |
| hist_data | input | 16 | History sample at hist_ptr |
| curve_raddr | input | 10 | Curve table read address |
| curve_rdata | output | 16 | Curve table word, one cycle latency |
| ctl_bits | output | 8 | Control: mode[2:0], RF[3], freq freeze[4], TTL out[5], history freeze[6], history select[7] |
| dac_hi | output | 16 | DAC upper limit |
| dac_lo | output | 16 | DAC lower limit |
| dac_park | output | 16 | DAC value while stopped |
| pulse_period | output | 16 | Pulse period in slow ticks |
| pulse_width | output | 16 | Pulse on-time in slow ticks |
| dac_manual | output | 16 | Manual DAC value |
| pid_div | output | 16 | Loop clock divisor |
| adc_setpoint | output | 16 | Loop target |
| gain_main | output | 8 | Main gain |
| gain_p | output | 8 | Proportional gain |
| gain_i | output | 8 | Integral gain |
| gain_d | output | 8 | Derivative gain |

## Verification
The assertions assume the host never raises `host_rd` and `host_wr` in the same cycle. They also assume that every strobe lasts a single cycle against a stable address. The pointer properties depend on this, because one address bus serves both kinds of access. The bench drives each access from a task that raises exactly one strobe for one cycle at the falling edge and drops it before the next access. Its history source is a pure function of `hist_ptr` and `ctl_bits[7]`, so every sample it expects is determined by its own pointer count.

// File: rtl/host_regs_pkg.sv
// Package: address map, storage masks and status packing for host_regfile.
// Assumes 5-bit addresses and 16-bit words.
package host_regs_pkg;

    localparam int DW     = 16;
    localparam int NREG   = 32;
    localparam int AW     = $clog2(NREG);

    localparam logic [AW-1:0] A_DAC_HI   = 5'd0;
    localparam logic [AW-1:0] A_DAC_LO   = 5'd1;
    localparam logic [AW-1:0] A_FREQ_MS  = 5'd2;
    localparam logic [AW-1:0] A_FREQ_LS  = 5'd3;
    localparam logic [AW-1:0] A_CTL      = 5'd6;
    localparam logic [AW-1:0] A_STATUS   = 5'd7;
    localparam logic [AW-1:0] A_PARK     = 5'd8;
    localparam logic [AW-1:0] A_PPERIOD  = 5'd10;
    localparam logic [AW-1:0] A_PWIDTH   = 5'd11;
    localparam logic [AW-1:0] A_MANUAL   = 5'd12;
    localparam logic [AW-1:0] A_GMAIN    = 5'd13;
    localparam logic [AW-1:0] A_PIDDIV   = 5'd14;
    localparam logic [AW-1:0] A_SETPT    = 5'd15;
    localparam logic [AW-1:0] A_GP       = 5'd16;
    localparam logic [AW-1:0] A_GI       = 5'd17;
    localparam logic [AW-1:0] A_GD       = 5'd18;
    localparam logic [AW-1:0] A_HIST     = 5'd19;
    localparam logic [AW-1:0] A_CURVE    = 5'd20;
    localparam logic [AW-1:0] A_VERSION  = 5'd21;
    localparam logic [AW-1:0] A_ADC_NOW  = 5'd22;
    localparam logic [AW-1:0] A_DAC_NOW  = 5'd23;

    // True for locations backed by host-written storage.
    function automatic bit is_writable(int a);
        case (a)
            0, 1, 6, 8, 10, 11, 12, 13, 14, 15, 16, 17, 18, 20: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Bits kept for each writable location.
    function automatic logic [DW-1:0] keep_mask(int a);
        case (a)
            6, 13, 16, 17, 18: return 16'h00FF;
            default:           return 16'hFFFF;
        endcase
    endfunction

    // Status word with printable-byte framing bits forced.
    function automatic logic [DW-1:0] pack_status(logic d_ovf, logic d_unf,
                                                  logic a_ovf, logic a_unf,
                                                  logic ttl);
        return {2'b01, 6'b000000, 2'b01, 1'b0, ttl, a_unf, a_ovf, d_unf, d_ovf};
    endfunction

endpackage

// File: rtl/hreg_store.sv
// Writable register storage. One flop word per writable location, with
// unwritten bits and non-writable locations tied to zero.
// Assumes wr_en is a single-cycle strobe qualified with waddr.
module hreg_store
    import host_regs_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = DW
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(N)-1:0]       waddr,
    input  logic [W-1:0]               wdata,
    output logic [N-1:0][W-1:0]        q
);
    localparam int LAW = $clog2(N);

    for (genvar i = 0; i < N; i++) begin : g_loc
        if (is_writable(i)) begin : g_rw
            // Capture masked host data on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q[i] <= '0;
                else if (wr_en && waddr == LAW'(i))
                    q[i] <= wdata & W'(keep_mask(i));
            end
        end else begin : g_ro
            assign q[i] = '0;
        end
    end

endmodule

// File: rtl/hreg_ptr.sv
// Wrapping address pointer with a clear that wins over advance.
// Assumes DEPTH is a power of two so that natural overflow wraps.
module hreg_ptr #(
    parameter int DEPTH = 1024,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    // Clear to zero, else step by one and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ptr <= '0;
        else if (adv)
            ptr <= ptr + 1'b1;
    end

endmodule

// File: rtl/hreg_curve_mem.sv
// Transfer-curve table: one write port from the host side, one registered
// read port for the output stage. Contents are not reset.
module hreg_curve_mem #(
    parameter int DEPTH = 1024,
    parameter int W     = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store one entry per write.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Registered read for the output stage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/host_regfile.sv
// Host register bank. Decodes host strobes, keeps writable settings,
// builds read data and moves the curve and history pointers on the
// accesses that own them. Assumes host_rd and host_wr never coincide.
module host_regfile
    import host_regs_pkg::*;
#(
    parameter int          CURVE_DEPTH = 1024,
    parameter int          HIST_DEPTH  = 1024,
    parameter logic [15:0] VERSION     = 16'h0107,
    localparam int         CW          = $clog2(CURVE_DEPTH),
    localparam int         HW          = $clog2(HIST_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    host_addr,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    input  logic          dac_ovf,
    input  logic          dac_unf,
    input  logic          acc_ovf,
    input  logic          acc_unf,
    input  logic          ttl_in,
    input  logic [31:0]   freq_count,
    input  logic [15:0]   adc_now,
    input  logic [15:0]   dac_now,
    output logic [HW-1:0] hist_ptr,
    input  logic [15:0]   hist_data,
    input  logic [CW-1:0] curve_raddr,
    output logic [15:0]   curve_rdata,
    output logic [7:0]    ctl_bits,
    output logic [15:0]   dac_hi,
    output logic [15:0]   dac_lo,
    output logic [15:0]   dac_park,
    output logic [15:0]   pulse_period,
    output logic [15:0]   pulse_width,
    output logic [15:0]   dac_manual,
    output logic [15:0]   pid_div,
    output logic [15:0]   adc_setpoint,
    output logic [7:0]    gain_main,
    output logic [7:0]    gain_p,
    output logic [7:0]    gain_i,
    output logic [7:0]    gain_d
);
    logic [NREG-1:0][DW-1:0] stored;
    logic [DW-1:0]           rd_word;
    logic [CW-1:0]           curve_waddr;
    logic                    status_rd;
    logic                    hist_rd;
    logic                    curve_wr;

    assign status_rd = host_rd && host_addr == A_STATUS;
    assign hist_rd   = host_rd && host_addr == A_HIST;
    assign curve_wr  = host_wr && host_addr == A_CURVE;

    hreg_store #(.N(NREG), .W(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (host_wr),
        .waddr (host_addr),
        .wdata (host_wdata),
        .q     (stored)
    );

    hreg_ptr #(.DEPTH(CURVE_DEPTH)) u_curve_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (status_rd),
        .adv   (curve_wr),
        .ptr   (curve_waddr)
    );

    hreg_ptr #(.DEPTH(HIST_DEPTH)) u_hist_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (status_rd),
        .adv   (hist_rd),
        .ptr   (hist_ptr)
    );

    hreg_curve_mem #(.DEPTH(CURVE_DEPTH), .W(DW)) u_curve (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (curve_wr),
        .waddr (curve_waddr),
        .wdata (host_wdata),
        .raddr (curve_raddr),
        .rdata (curve_rdata)
    );

    // Select the word presented for the current read address.
    always_comb begin
        case (host_addr)
            A_FREQ_MS: rd_word = freq_count[31:16];
            A_FREQ_LS: rd_word = freq_count[15:0];
            A_STATUS:  rd_word = pack_status(dac_ovf, dac_unf, acc_ovf, acc_unf, ttl_in);
            A_HIST:    rd_word = hist_data;
            A_VERSION: rd_word = VERSION;
            A_ADC_NOW: rd_word = adc_now;
            A_DAC_NOW: rd_word = dac_now;
            default:   rd_word = stored[host_addr];
        endcase
    end

    // Latch read data only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (host_rd)
            host_rdata <= rd_word;
    end

    assign ctl_bits     = stored[A_CTL][7:0];
    assign dac_hi       = stored[A_DAC_HI];
    assign dac_lo       = stored[A_DAC_LO];
    assign dac_park     = stored[A_PARK];
    assign pulse_period = stored[A_PPERIOD];
    assign pulse_width  = stored[A_PWIDTH];
    assign dac_manual   = stored[A_MANUAL];
    assign pid_div      = stored[A_PIDDIV];
    assign adc_setpoint = stored[A_SETPT];
    assign gain_main    = stored[A_GMAIN][7:0];
    assign gain_p       = stored[A_GP][7:0];
    assign gain_i       = stored[A_GI][7:0];
    assign gain_d       = stored[A_GD][7:0];

endmodule

// File: rtl/host_regfile_chk.sv
// Protocol and pointer properties for host_regfile, attached by bind.
module host_regfile_chk #(
    parameter int CW = 10,
    parameter int HW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic [4:0]    host_addr,
    input logic          host_wr,
    input logic          host_rd,
    input logic [15:0]   host_rdata,
    input logic [HW-1:0] hist_ptr,
    input logic [CW-1:0] curve_waddr
);
    // Host protocol: strobes never overlap (input assumption, R10).
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && host_wr));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    p_status_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == 5'd7 |=>
            host_rdata[15:14] == 2'b01 && host_rdata[7:5] == 3'b010 && host_rdata[13:8] == 6'd0);

    p_ptr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == 5'd7 |=> hist_ptr == '0 && curve_waddr == '0);

    p_hist_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr == 5'd19 |=> hist_ptr == HW'($past(hist_ptr) + 1'b1));

    p_curve_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr == 5'd20 |=> curve_waddr == CW'($past(curve_waddr) + 1'b1));

    p_ptrs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd && !host_wr |=> $stable(hist_ptr) && $stable(curve_waddr));

endmodule

bind host_regfile host_regfile_chk #(.CW(CW), .HW(HW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_rdata  (host_rdata),
    .hist_ptr    (hist_ptr),
    .curve_waddr (curve_waddr)
);

// File: tb/test_host_regfile.sv
`timescale 1ns/1ps
module test_host_regfile;

    typedef struct {
        logic [15:0] v;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  host_addr = '0;
    logic        host_wr = 0, host_rd = 0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        dac_ovf = 0, dac_unf = 0, acc_ovf = 0, acc_unf = 0, ttl_in = 0;
    logic [31:0] freq_count = 32'h1234_5678;
    logic [15:0] adc_now = 16'h0A0A, dac_now = 16'h0D0D;
    logic [9:0]  hist_ptr;
    logic [15:0] hist_data;
    logic [9:0]  curve_raddr = '0;
    logic [15:0] curve_rdata;
    logic [7:0]  ctl_bits;
    logic [15:0] dac_hi, dac_lo, dac_park, pulse_period, pulse_width, dac_manual, pid_div, adc_setpoint;
    logic [7:0]  gain_main, gain_p, gain_i, gain_d;

    int   checks = 0, errors = 0;
    int   bptr = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    // External history store model: source tag in the top nibble, pointer below.
    assign hist_data = {(ctl_bits[7] ? 4'hD : 4'hA), 2'b00, hist_ptr};

    host_regfile i_host_regfile (.*);

    function automatic logic [15:0] hsample(bit sel, int p);
        return {(sel ? 4'hD : 4'hA), 2'b00, 10'(p)};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(logic [4:0] a, logic [15:0] e, string tag);
        exp_t it;
        @(negedge clk);
        host_addr = a; host_rd = 1;
        it.v = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic curve_at(int a, logic [15:0] e, string tag);
        @(negedge clk);
        curve_raddr = 10'(a);
        @(negedge clk);
        chk(tag, curve_rdata, e);
    endtask

    // Monitor: pop one expected word per read strobe seen at an edge.
    initial begin
        forever begin
            logic s;
            @(posedge clk);
            s = host_rd;
            @(negedge clk);
            if (s) begin
                exp_t it;
                if (sb.size() == 0) begin
                    chk("R10 unexpected read", host_rdata, 16'hxxxx);
                end else begin
                    it = sb.pop_front();
                    chk(it.tag, host_rdata, it.v);
                end
            end
        end
    end

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        chk("R10 reset rdata", host_rdata, 16'h0000);
        chk("R1 reset dac_hi", dac_hi, 16'h0000);
        chk("R7 reset hist_ptr", {6'd0, hist_ptr}, 16'h0000);

        // R1 full-width storage
        wr(5'd0, 16'hBEEF);  wr(5'd1, 16'h1357);  wr(5'd12, 16'hFACE);  wr(5'd15, 16'h8001);
        rd(5'd0, 16'hBEEF, "R1 loc0");
        rd(5'd1, 16'h1357, "R1 loc1");
        rd(5'd12, 16'hFACE, "R1 loc12");
        @(negedge clk);
        chk("R1 dac_manual port", dac_manual, 16'hFACE);
        chk("R1 adc_setpoint port", adc_setpoint, 16'h8001);

        // R2 narrow locations
        wr(5'd16, 16'hABCD); wr(5'd6, 16'h5A80);
        rd(5'd16, 16'h00CD, "R2 gain_p loc");
        rd(5'd6, 16'h0080, "R2 ctl loc");
        @(negedge clk);
        chk("R2 gain_p port", {8'd0, gain_p}, 16'h00CD);
        wr(5'd6, 16'h0000);

        // R3 writes to read-only and unused locations
        wr(5'd5, 16'hFFFF); wr(5'd21, 16'h0000); wr(5'd2, 16'h0000); wr(5'd30, 16'h7777);
        rd(5'd5, 16'h0000, "R3 unused loc5");
        rd(5'd30, 16'h0000, "R3 unused loc30");
        rd(5'd0, 16'hBEEF, "R3 loc0 untouched");

        // R9 live and fixed values
        rd(5'd2, 16'h1234, "R9 freq ms");
        rd(5'd3, 16'h5678, "R9 freq ls");
        rd(5'd21, 16'h0107, "R9 version");
        rd(5'd22, 16'h0A0A, "R9 adc now");
        rd(5'd23, 16'h0D0D, "R9 dac now");

        // R4 status word
        rd(5'd7, 16'h4040, "R4 status idle");
        dac_ovf = 1; acc_unf = 1; ttl_in = 1;
        rd(5'd7, 16'h4059, "R4 status flags a");
        dac_ovf = 0; acc_unf = 0; ttl_in = 0; dac_unf = 1; acc_ovf = 1;
        rd(5'd7, 16'h4046, "R4 status flags b");
        dac_unf = 0; acc_ovf = 0;

        // R10 hold
        wr(5'd8, 16'h2222);
        @(negedge clk);
        chk("R10 rdata holds", host_rdata, 16'h4046);

        // R7 history reads advance
        bptr = 0;
        for (int k = 0; k < 3; k++) begin
            rd(5'd19, hsample(0, bptr), "R7 adc history");
            bptr++;
        end
        wr(5'd6, 16'h0080);
        rd(5'd19, hsample(1, bptr), "R7 dac history");
        bptr++;
        // R5 status read clears both pointers
        rd(5'd7, 16'h4040, "R5 status");
        bptr = 0;
        rd(5'd19, hsample(1, 0), "R5 hist restart");
        bptr = 1;
        wr(5'd6, 16'h0000);

        // R6 curve writes
        rd(5'd7, 16'h4040, "R5 status before curve");
        wr(5'd20, 16'h1111); wr(5'd20, 16'h2222); wr(5'd20, 16'h3333);
        curve_at(0, 16'h1111, "R6 curve 0");
        curve_at(2, 16'h3333, "R6 curve 2");
        rd(5'd20, 16'h3333, "R6 loc20 last word");
        rd(5'd7, 16'h4040, "R5 status resets curve");
        wr(5'd20, 16'h9999);
        curve_at(0, 16'h9999, "R5 curve rewrites 0");
        curve_at(1, 16'h2222, "R6 curve 1 kept");

        // R8 curve wrap
        rd(5'd7, 16'h4040, "R5 status before wrap");
        for (int k = 0; k < 1025; k++) wr(5'd20, 16'(k));
        curve_at(0, 16'd1024, "R8 curve wrap entry 0");
        curve_at(1, 16'd1, "R8 curve entry 1");
        curve_at(1023, 16'd1023, "R8 curve entry 1023");

        // R8 history wrap
        rd(5'd7, 16'h4040, "R5 status before hist wrap");
        for (int k = 0; k < 1024; k++) rd(5'd19, hsample(0, k), "R7 hist sweep");
        rd(5'd19, hsample(0, 0), "R8 hist wrap");

        finish_run();
    end

endmodule